// File: doc/BRIEF.md
# RGB Panel Raster Timing Generator

This block produces the raster timing for a parallel RGB display panel. A system clock is divided down into a one-cycle pixel strobe, and on each strobe a horizontal and a vertical position counter advance through four regions per axis: sync pulse, back porch, active area and front porch. From these counters the block derives horizontal sync, vertical sync, a data-enable strobe, the zero-based column and line inside the active area, and a separate frame-marker pulse. The marker has its own line offset, width, polarity and frame rate, so a panel driver can use it as a slow per-frame tick.

All geometry fields are static inputs holding a count minus one. The block latches them into shadow registers while idle and again at each frame boundary, so a field changed in mid-frame cannot break the frame in progress. Lowering the video enable lets the current frame run to its end before the outputs go idle. Raising the video enable again starts a new frame at its vertical sync. A clock-mode input chooses whether the pixel strobe stops while idle or keeps running.

Top module: `rgb_panel_timing`

## Requirements
- R1: Every line is h_sync_len+1 pixel periods with hsync active, then h_back_len+1 pixel periods of back porch, then h_act_len+1 active pixels, then h_front_len+1 pixel periods of front porch, and then the line repeats. Each field holds its count minus one.
- R2: Every frame is v_sync_len+1 lines with vsync active, then v_back_len+1 back-porch lines, then v_act_len+1 active lines, then v_front_len+1 front-porch lines, with the same minus-one coding. A running frame begins at line 0, pixel 0.
- R3: pix_ce is high for exactly one system clock once every clk_div+1 system clocks. A clk_div value of 0 behaves as 1, so the fastest pixel rate is half the system clock.
- R4: With free_run=0, pix_ce stays low while the block is idle. With free_run=1, pix_ce keeps pulsing at the same spacing while idle.
- R5: hs_pol and vs_pol select the sync level: 0 means active high and 1 means active low. While idle, hsync and vsync rest at their inactive level.
- R6: With vs_out_en=0, vsync stays inactive for the whole frame while the counters keep running, and de and fmark follow their normal timing.
- R7: de is high exactly when both counters are inside their active regions. While de is high, pix_x and pix_y give the zero-based column and line inside the active area; otherwise both are 0.
- R8: With fm_en=1, fmark is active for whole lines, from line F+fm_gap through line F+fm_gap+fm_len inclusive, where F is the first front-porch line. fm_pol=0 makes fmark active high and fm_pol=1 makes it active low. With fm_en=0, fmark stays inactive.
- R9: fmark appears in the first frame after a start and then in every (fm_rate+1)-th frame. fm_rate is 4 bits wide, so the slowest rate is one frame in 16.
- R10: A configuration change made during a running frame takes effect at the first pixel of the next frame. While idle, the configuration is taken in every cycle.
- R11: When video_en goes low, the current frame completes and the outputs then return to idle. Raising video_en again starts a new frame at line 0, pixel 0, in vertical sync.
- R12: During reset, pix_ce, hsync, vsync, de, fmark, pix_x and pix_y are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| video_en | input | 1 | Run frames while high; stop at frame end when low |
| free_run | input | 1 | 1: pixel strobe also runs while idle |
| hs_pol | input | 1 | hsync polarity, 0 active high |
| vs_pol | input | 1 | vsync polarity, 0 active high |
| vs_out_en | input | 1 | 0 holds vsync inactive |
| h_sync_len | input | 10 | Horizontal sync width minus one |
| h_back_len | input | 10 | Horizontal back porch minus one |
| h_act_len | input | 10 | Active pixels per line minus one |
| h_front_len | input | 10 | Horizontal front porch minus one |
| v_sync_len | input | 10 | Vertical sync width in lines minus one |
| v_back_len | input | 10 | Vertical back porch minus one |
| v_act_len | input | 10 | Active lines minus one |
| v_front_len | input | 10 | Vertical front porch minus one |
| clk_div | input | 8 | Pixel divider minus one, minimum effective 1 |
| fm_en | input | 1 | Frame-marker enable |
| fm_pol | input | 1 | Frame-marker polarity, 0 active high |
| fm_rate | input | 4 | Marker issued every fm_rate+1 frames |
| fm_gap | input | 8 | Lines between the first front-porch line and the marker start |
| fm_len | input | 8 | Marker width in lines minus one |
| pix_ce | output | 1 | Pixel clock strobe |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, active high |
| fmark | output | 1 | Frame-marker pulse |
| pix_x | output | 10 | Active column, 0 when de is low |
| pix_y | output | 10 | Active line, 0 when de is low |

## Verification
A wrong count in either position counter moves an hsync, vsync or de edge. The horizontal error shows within one line and the vertical error within one frame, so the bench compares every output on every system cycle against a position computed arithmetically from the number of pixel strobes since the start. A divider fault shows at the second pixel strobe after a start or a configuration change, through the measured strobe spacing. A shadow-register fault shows as a line length changing before the frame boundary. A marker counter fault shows as the marker missing or appearing in the wrong frame within fm_rate+1 frames.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    // geometry field width, divider width, marker field widths
    parameter int FW = 10;
    parameter int DW = 8;
    parameter int MW = 8;
    parameter int RW = 4;
    parameter int CW = FW + 2;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_e;

    typedef struct packed {
        logic [FW-1:0] hsw;
        logic [FW-1:0] hbp;
        logic [FW-1:0] hact;
        logic [FW-1:0] hfp;
        logic [FW-1:0] vsw;
        logic [FW-1:0] vbp;
        logic [FW-1:0] vact;
        logic [FW-1:0] vfp;
        logic [DW-1:0] div;
        logic          free_run;
        logic          hs_pol;
        logic          vs_pol;
        logic          vs_en;
        logic          fm_en;
        logic          fm_pol;
        logic [RW-1:0] fm_rate;
        logic [MW-1:0] fm_gap;
        logic [MW-1:0] fm_len;
    } cfg_t;
endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [DW-1:0] div,
    output logic          ce
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } div_st_t;

    div_st_t       div_q, div_d;
    logic [DW-1:0] div_eff;

    always_comb begin
        div_d   = div_q;
        div_eff = (div == '0) ? {{(DW-1){1'b0}}, 1'b1} : div;
        ce      = run && (div_q.cnt >= div_eff);
        if (restart || !run) begin
            div_d.cnt = '0;
        end else if (ce) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R3
    ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> !ce);
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
    parameter int FW = 10,
    parameter int CW = FW + 2
) (
    input  logic [FW-1:0] sw,
    input  logic [FW-1:0] bp,
    input  logic [FW-1:0] act,
    input  logic [FW-1:0] fp,
    input  logic [CW-1:0] pos,
    output logic          in_sync,
    output logic          in_act,
    output logic          last,
    output logic [FW-1:0] rel
);
    logic [CW-1:0] sync_end;
    logic [CW-1:0] act_beg;
    logic [CW-1:0] act_end;
    logic [CW-1:0] total;

    always_comb begin
        sync_end = CW'(sw) + CW'(1);
        act_beg  = sync_end + CW'(bp) + CW'(1);
        act_end  = act_beg + CW'(act) + CW'(1);
        total    = act_end + CW'(fp) + CW'(1);
        in_sync  = pos < sync_end;
        in_act   = (pos >= act_beg) && (pos < act_end);
        last     = pos == (total - CW'(1));
        rel      = in_act ? FW'(pos - act_beg) : '0;
    end
endmodule

// File: rtl/lcdt_fmark.sv
module lcdt_fmark #(
    parameter int CW = 12,
    parameter int RW = 4,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wrap,
    input  logic          run,
    input  logic          en,
    input  logic          pol,
    input  logic [RW-1:0] rate,
    input  logic [MW-1:0] gap,
    input  logic [MW-1:0] len,
    input  logic [CW-1:0] fp_line,
    input  logic [CW-1:0] line,
    output logic          fmark
);
    typedef struct packed {
        logic [RW-1:0] fcnt;
    } fm_st_t;

    fm_st_t      fm_q, fm_d;
    logic [CW:0] win_beg;
    logic [CW:0] win_end;
    logic        on;

    always_comb begin
        fm_d = fm_q;
        if (start) begin
            fm_d.fcnt = '0;
        end else if (wrap) begin
            fm_d.fcnt = (fm_q.fcnt >= rate) ? '0 : fm_q.fcnt + 1'b1;
        end
        win_beg = {1'b0, fp_line} + (CW+1)'(gap);
        win_end = win_beg + (CW+1)'(len) + (CW+1)'(1);
        on      = run && en && (fm_q.fcnt == '0) &&
                  ({1'b0, line} >= win_beg) && ({1'b0, line} < win_end);
        fmark   = on ^ pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fm_q <= '0;
        else        fm_q <= fm_d;
    end

    // R9
    fm_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap && (fm_q.fcnt >= rate)) |=> (fm_q.fcnt == '0));
endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    video_en,
    input  logic                    free_run,
    input  logic                    hs_pol,
    input  logic                    vs_pol,
    input  logic                    vs_out_en,
    input  logic [lcdt_pkg::FW-1:0] h_sync_len,
    input  logic [lcdt_pkg::FW-1:0] h_back_len,
    input  logic [lcdt_pkg::FW-1:0] h_act_len,
    input  logic [lcdt_pkg::FW-1:0] h_front_len,
    input  logic [lcdt_pkg::FW-1:0] v_sync_len,
    input  logic [lcdt_pkg::FW-1:0] v_back_len,
    input  logic [lcdt_pkg::FW-1:0] v_act_len,
    input  logic [lcdt_pkg::FW-1:0] v_front_len,
    input  logic [lcdt_pkg::DW-1:0] clk_div,
    input  logic                    fm_en,
    input  logic                    fm_pol,
    input  logic [lcdt_pkg::RW-1:0] fm_rate,
    input  logic [lcdt_pkg::MW-1:0] fm_gap,
    input  logic [lcdt_pkg::MW-1:0] fm_len,
    output logic                    pix_ce,
    output logic                    hsync,
    output logic                    vsync,
    output logic                    de,
    output logic                    fmark,
    output logic [lcdt_pkg::FW-1:0] pix_x,
    output logic [lcdt_pkg::FW-1:0] pix_y
);
    localparam int FW    = lcdt_pkg::FW;
    localparam int DW    = lcdt_pkg::DW;
    localparam int MW    = lcdt_pkg::MW;
    localparam int RW    = lcdt_pkg::RW;
    localparam int CW    = lcdt_pkg::CW;
    localparam int NAXIS = 2;

    typedef struct packed {
        lcdt_pkg::run_e st;
        logic [CW-1:0]  h;
        logic [CW-1:0]  v;
        lcdt_pkg::cfg_t sh;
    } tg_st_t;

    tg_st_t         q, d;
    lcdt_pkg::cfg_t live;
    logic           running;
    logic           start;
    logic           adv;
    logic           wrap;
    logic [CW-1:0]  fp_line;

    logic [NAXIS-1:0][FW-1:0] ax_sw, ax_bp, ax_act, ax_fp, ax_rel;
    logic [NAXIS-1:0][CW-1:0] ax_pos;
    logic [NAXIS-1:0]         ax_sync, ax_in, ax_last;

    always_comb begin
        live.hsw      = h_sync_len;
        live.hbp      = h_back_len;
        live.hact     = h_act_len;
        live.hfp      = h_front_len;
        live.vsw      = v_sync_len;
        live.vbp      = v_back_len;
        live.vact     = v_act_len;
        live.vfp      = v_front_len;
        live.div      = clk_div;
        live.free_run = free_run;
        live.hs_pol   = hs_pol;
        live.vs_pol   = vs_pol;
        live.vs_en    = vs_out_en;
        live.fm_en    = fm_en;
        live.fm_pol   = fm_pol;
        live.fm_rate  = fm_rate;
        live.fm_gap   = fm_gap;
        live.fm_len   = fm_len;
    end

    always_comb begin
        ax_sw[0]  = q.sh.hsw;  ax_sw[1]  = q.sh.vsw;
        ax_bp[0]  = q.sh.hbp;  ax_bp[1]  = q.sh.vbp;
        ax_act[0] = q.sh.hact; ax_act[1] = q.sh.vact;
        ax_fp[0]  = q.sh.hfp;  ax_fp[1]  = q.sh.vfp;
        ax_pos[0] = q.h;       ax_pos[1] = q.v;
    end

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        lcdt_axis #(.FW(FW), .CW(CW)) u_axis (
            .sw      (ax_sw[a]),
            .bp      (ax_bp[a]),
            .act     (ax_act[a]),
            .fp      (ax_fp[a]),
            .pos     (ax_pos[a]),
            .in_sync (ax_sync[a]),
            .in_act  (ax_in[a]),
            .last    (ax_last[a]),
            .rel     (ax_rel[a])
        );
    end

    assign running = (q.st == lcdt_pkg::ST_RUN);

    lcdt_clkdiv #(.DW(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.sh.free_run || running),
        .restart (start),
        .div     (q.sh.div),
        .ce      (pix_ce)
    );

    always_comb begin
        d       = q;
        start   = (q.st == lcdt_pkg::ST_IDLE) && video_en;
        adv     = running && pix_ce;
        wrap    = adv && ax_last[0] && ax_last[1];
        fp_line = CW'(q.sh.vsw) + CW'(q.sh.vbp) + CW'(q.sh.vact) + CW'(3);

        if (!running || wrap) begin
            d.sh = live;
        end
        if (start) begin
            d.st = lcdt_pkg::ST_RUN;
            d.h  = '0;
            d.v  = '0;
        end else if (adv) begin
            if (ax_last[0]) begin
                d.h = '0;
                d.v = ax_last[1] ? '0 : q.v + CW'(1);
            end else begin
                d.h = q.h + CW'(1);
            end
            if (wrap && !video_en) begin
                d.st = lcdt_pkg::ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    lcdt_fmark #(.CW(CW), .RW(RW), .MW(MW)) u_fmark (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wrap    (wrap),
        .run     (running),
        .en      (q.sh.fm_en),
        .pol     (q.sh.fm_pol),
        .rate    (q.sh.fm_rate),
        .gap     (q.sh.fm_gap),
        .len     (q.sh.fm_len),
        .fp_line (fp_line),
        .line    (q.v),
        .fmark   (fmark)
    );

    always_comb begin
        hsync = (running && ax_sync[0]) ^ q.sh.hs_pol;
        vsync = (running && ax_sync[1] && q.sh.vs_en) ^ q.sh.vs_pol;
        de    = running && ax_in[0] && ax_in[1];
        pix_x = de ? ax_rel[0] : '0;
        pix_y = de ? ax_rel[1] : '0;
    end

    // R1
    h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !pix_ce) |=> $stable(q.h));

    // R1
    h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pix_ce && ax_last[0]) |=> (q.h == '0));

    // R2
    v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pix_ce && ax_last[0] && !ax_last[1]) |=> (q.v == $past(q.v) + CW'(1)));

    // R7
    de_no_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync == q.sh.hs_pol));

    // R8
    fmark_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmark != q.sh.fm_pol) |-> !de);

    // R11
    stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(running)) |-> $past(ax_last[0] && ax_last[1] && pix_ce));
endmodule

// File: tb/tb_rgb_panel_timing.sv
module tb_rgb_panel_timing;
    localparam int FW = lcdt_pkg::FW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic video_en = 1'b0;
    lcdt_pkg::cfg_t live = '0;

    logic          pix_ce, hsync, vsync, de, fmark;
    logic [FW-1:0] pix_x, pix_y;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rgb_panel_timing dut (
        .clk(clk), .rst_n(rst_n), .video_en(video_en),
        .free_run(live.free_run), .hs_pol(live.hs_pol), .vs_pol(live.vs_pol),
        .vs_out_en(live.vs_en),
        .h_sync_len(live.hsw), .h_back_len(live.hbp), .h_act_len(live.hact),
        .h_front_len(live.hfp),
        .v_sync_len(live.vsw), .v_back_len(live.vbp), .v_act_len(live.vact),
        .v_front_len(live.vfp),
        .clk_div(live.div), .fm_en(live.fm_en), .fm_pol(live.fm_pol),
        .fm_rate(live.fm_rate), .fm_gap(live.fm_gap), .fm_len(live.fm_len),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de), .fmark(fmark),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic int ht_of(lcdt_pkg::cfg_t c);
        return int'(c.hsw) + int'(c.hbp) + int'(c.hact) + int'(c.hfp) + 4;
    endfunction
    function automatic int vt_of(lcdt_pkg::cfg_t c);
        return int'(c.vsw) + int'(c.vbp) + int'(c.vact) + int'(c.vfp) + 4;
    endfunction

    // bench model state
    bit run_m = 0;
    bit prev_ce = 0;
    bit gap_ok = 0;
    int k = 0;
    int fr = 0;
    int gap = 0;
    lcdt_pkg::cfg_t cm = '0;
    lcdt_pkg::cfg_t prev_live = '0;

    always @(negedge clk) begin : monitor
        if (!rst_n) begin
            run_m = 0; prev_ce = 0; gap_ok = 0; k = 0; fr = 0; gap = 0;
            cm = live; prev_live = live;
        end else begin : active
            bit started;
            int ht, h, v, deff, ab_h, ab_v, fe;
            bit e_hs, e_vs, e_de, e_fm, e_hin, e_vin;
            int e_x, e_y;
            started = 0;
            if (!run_m) begin
                cm = live;
                if (video_en) begin
                    run_m = 1; k = 0; fr = 0; started = 1;
                end
            end else if (prev_ce) begin
                k++;
                if (k == ht_of(cm) * vt_of(cm)) begin
                    cm = live; k = 0; fr++;
                    if (!video_en) run_m = 0;
                end
            end
            if (live.div != prev_live.div || live.free_run != prev_live.free_run) gap_ok = 0;
            prev_live = live;
            gap++;
            if (started) begin gap = 1; gap_ok = 1; end
            deff = (cm.div == 0) ? 1 : int'(cm.div);
            if (pix_ce) begin
                // R3 strobe spacing
                if (gap_ok) chk(gap == deff + 1, "R3 pix_ce spacing", gap, deff + 1);
                gap = 0; gap_ok = 1;
            end
            // R4 no strobe while idle in normal mode
            if (!run_m && !cm.free_run) chk(pix_ce == 1'b0, "R4 idle pix_ce", int'(pix_ce), 0);
            prev_ce = pix_ce;

            ht = ht_of(cm);
            h = k % ht;
            v = k / ht;
            ab_h = int'(cm.hsw) + int'(cm.hbp) + 2;
            ab_v = int'(cm.vsw) + int'(cm.vbp) + 2;
            fe = ab_v + int'(cm.vact) + 1;
            e_hin = (h >= ab_h) && (h < ab_h + int'(cm.hact) + 1);
            e_vin = (v >= ab_v) && (v < fe);
            e_hs = (run_m && h < int'(cm.hsw) + 1) ^ cm.hs_pol;
            e_vs = (run_m && cm.vs_en && v < int'(cm.vsw) + 1) ^ cm.vs_pol;
            e_de = run_m && e_hin && e_vin;
            e_x = e_de ? h - ab_h : 0;
            e_y = e_de ? v - ab_v : 0;
            e_fm = (run_m && cm.fm_en && (fr % (int'(cm.fm_rate) + 1) == 0) &&
                    v >= fe + int'(cm.fm_gap) &&
                    v < fe + int'(cm.fm_gap) + int'(cm.fm_len) + 1) ^ cm.fm_pol;
            chk(hsync == e_hs, "R1 R5 R10 hsync", int'(hsync), int'(e_hs));
            chk(vsync == e_vs, "R2 R5 R6 vsync", int'(vsync), int'(e_vs));
            chk(de == e_de, "R7 R10 de", int'(de), int'(e_de));
            chk(int'(pix_x) == e_x, "R7 pix_x", int'(pix_x), e_x);
            chk(int'(pix_y) == e_y, "R7 pix_y", int'(pix_y), e_y);
            chk(fmark == e_fm, "R8 R9 fmark", int'(fmark), int'(e_fm));
        end
    end

    task automatic drive_step();
        @(negedge clk); #1;
    endtask

    task automatic wait_stop();
        while (run_m) @(negedge clk);
        #1;
    endtask

    task automatic idle_checks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            // R11 idle levels after the frame ran out
            chk(de == 1'b0, "R11 idle de", int'(de), 0);
            chk(hsync == live.hs_pol, "R11 idle hsync", int'(hsync), int'(live.hs_pol));
            chk(vsync == live.vs_pol, "R11 idle vsync", int'(vsync), int'(live.vs_pol));
            chk(fmark == live.fm_pol, "R11 idle fmark", int'(fmark), int'(live.fm_pol));
        end
        #1;
    endtask

    initial begin : stim
        lcdt_pkg::cfg_t c;
        // R12 reset state
        repeat (2) @(negedge clk);
        chk(pix_ce == 1'b0, "R12 reset pix_ce", int'(pix_ce), 0);
        chk(hsync == 1'b0, "R12 reset hsync", int'(hsync), 0);
        chk(vsync == 1'b0, "R12 reset vsync", int'(vsync), 0);
        chk(de == 1'b0, "R12 reset de", int'(de), 0);
        chk(fmark == 1'b0, "R12 reset fmark", int'(fmark), 0);
        chk(pix_x == '0 && pix_y == '0, "R12 reset position", int'(pix_x) + int'(pix_y), 0);
        #1 rst_n = 1'b1;

        // configuration A: normal clock mode, marker every other frame
        c = '0;
        c.hsw = 1; c.hbp = 1; c.hact = 3; c.hfp = 0;
        c.vsw = 0; c.vbp = 1; c.vact = 2; c.vfp = 2;
        c.div = 1; c.vs_en = 1; c.fm_en = 1; c.fm_rate = 1; c.fm_gap = 0; c.fm_len = 1;
        drive_step(); live = c;
        repeat (10) drive_step();
        video_en = 1'b1;
        repeat (4 * 81 * 2 + 37) drive_step();
        video_en = 1'b0;
        wait_stop();
        idle_checks(8);
        // R11 restart from a fresh frame
        video_en = 1'b1;
        repeat (100) drive_step();
        video_en = 1'b0;
        wait_stop();
        idle_checks(4);

        // configuration B: free-run, inverted polarities, vsync gated off, divider 0
        c = '0;
        c.hsw = 0; c.hbp = 0; c.hact = 1; c.hfp = 1;
        c.vsw = 1; c.vbp = 0; c.vact = 1; c.vfp = 1;
        c.div = 0; c.free_run = 1; c.hs_pol = 1; c.vs_pol = 1; c.vs_en = 0;
        c.fm_en = 1; c.fm_pol = 1; c.fm_rate = 0; c.fm_gap = 0; c.fm_len = 0;
        live = c;
        repeat (20) drive_step();
        video_en = 1'b1;
        repeat (3 * 42 * 2 + 5) drive_step();
        video_en = 1'b0;
        wait_stop();
        idle_checks(20);

        // configuration C: slower divider, marker every third frame, mid-frame edit
        c = '0;
        c.hsw = 2; c.hbp = 3; c.hact = 5; c.hfp = 1;
        c.vsw = 1; c.vbp = 1; c.vact = 3; c.vfp = 3;
        c.div = 3; c.vs_en = 1; c.fm_en = 1; c.fm_rate = 2; c.fm_gap = 1; c.fm_len = 1;
        live = c;
        repeat (5) drive_step();
        video_en = 1'b1;
        repeat (200) drive_step();
        // R10 active width shrinks only from the next frame on
        live.hact = 2;
        repeat (2600) drive_step();
        video_en = 1'b0;
        wait_stop();
        idle_checks(6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule